// File: doc/BRIEF.md
# I2C Serial Clock Generator with Prescaler and Phase Dividers

This block derives the serial clock line level for an I2C bit engine from the module clock. A programmable prescaler first divides the module clock into an internal tick, normally close to 1 MHz; for example, a setting of 26 from a 27 MHz clock gives a 1 MHz tick. Two phase counters then count those ticks. One sets the time SCL is low and the other the time it is high. Each phase lasts its programmed count plus a fixed extra count that depends on the prescaler setting. The extra count is 7 for a prescaler of 0, 6 for 1 and 5 for 2 or more. One full SCL period therefore lasts (psc+1) * ((low+d) + (high+d)) module clocks. Software normally splits that period evenly between the two phases.

The prescaler value and the two phase counts are loaded through a small write-only register port. A write is accepted only while the module-enable input is low, which holds the block in its internal reset. While the enable is low, SCL is held high and every counter is cleared. When the enable rises, SCL starts in its high phase. The block then alternates phases and emits a one-cycle strobe on each edge of SCL, which a bit engine uses to time its data changes. All control pins are plain levels. There is no data stream and no valid/ready handshake, because the block neither accepts nor produces data items.

Top module: `scl_clkgen`

## Requirements
- R1: While mod_en is 0, from the next clock edge onward scl_o is 1 and tick_o, scl_rise_o and scl_fall_o are 0. The same holds during rst_n low.
- R2: A write (cfg_wr = 1) is accepted only while mod_en is 0. cfg_sel 0 loads the prescaler from the low bits of cfg_wdata, 1 loads the low count and 2 loads the high count. Writes with cfg_sel 3, and any write made while mod_en is 1, leave the timing unchanged.
- R3: While enabled, tick_o is high for one cycle in every psc+1 cycles. The first tick is visible psc+1 cycles after the enable edge (the edge that first samples mod_en = 1 counts as cycle 1).
- R4: The extra count d is 7 when psc = 0, 6 when psc = 1 and 5 when psc >= 2. A low phase spans exactly low+d ticks and a high phase spans exactly high+d ticks.
- R5: After enable, scl_o stays high and first reads 0 at cycle (high+d)*(psc+1)+1, counted as in R3.
- R6: Each later low phase lasts (low+d)*(psc+1) module clocks and each high phase lasts (high+d)*(psc+1) module clocks.
- R7: scl_fall_o is 1 exactly in the first cycle scl_o reads 0, and scl_rise_o is 1 exactly in the first cycle scl_o reads 1 after a low phase. Otherwise both are 0, and the two are never 1 together.
- R8: Dropping mod_en in mid-phase returns scl_o to 1 on the next edge. A later enable restarts the timing of R5 from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; 0 holds the block in reset and opens the register port |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 prescaler, 1 low count, 2 high count, 3 none |
| cfg_wdata | input | CNT_W (16) | Write data |
| tick_o | output | 1 | Prescaled internal tick, one cycle wide |
| scl_o | output | 1 | SCL drive level |
| scl_rise_o | output | 1 | One-cycle strobe in the first cycle of a high phase |
| scl_fall_o | output | 1 | One-cycle strobe in the first cycle of a low phase |

## Verification
The assertions check several rules on every cycle:
- the outputs go quiet whenever the block is disabled;
- configuration registers do not change while the block is enabled;
- two ticks are never adjacent when the prescaler is non-zero;
- SCL changes level only after a tick;
- each strobe matches an actual SCL edge, and the two strobes never coincide.

The exact counts cannot be shown by a property: the first-fall delay, the phase lengths in module clocks, the extra count chosen for each prescaler value, and the restart after a mid-phase disable. The bench shows these by sweeping every prescaler from 0 to 3 against small low and high counts and comparing the measured cycles with the arithmetic formulas.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [1:0] {
    SEL_PSC  = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_HIGH = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_t;

  // Extra ticks added to each phase, chosen by prescaler value (R4)
  function automatic logic [3:0] extra_ticks(input logic [31:0] psc);
    if (psc == 32'd0)      return 4'd7;
    else if (psc == 32'd1) return 4'd6;
    else                   return 4'd5;
  endfunction

endpackage

// File: rtl/sclgen_cfg.sv
module sclgen_cfg #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] wdata,
  output logic [PSC_W-1:0] psc_q,
  output logic [CNT_W-1:0] low_q,
  output logic [CNT_W-1:0] high_q
);
  import sclgen_pkg::*;

  logic accept;
  assign accept = wr && !en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else if (accept) begin
      case (cfg_sel_t'(sel))
        SEL_PSC:  psc_q  <= wdata[PSC_W-1:0];
        SEL_LOW:  low_q  <= wdata;
        SEL_HIGH: high_q <= wdata;
        default:  ;
      endcase
    end
  end

  // R2: configuration frozen while the module runs
  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && en) |=> ($stable(psc_q) && $stable(low_q) && $stable(high_q)));

endmodule

// File: rtl/sclgen_presc.sv
module sclgen_presc #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] pcnt;
  logic             wrap;

  assign wrap = (pcnt == psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      tick <= 1'b0;
    end else if (!en) begin
      pcnt <= '0;
      tick <= 1'b0;
    end else begin
      pcnt <= wrap ? '0 : pcnt + 1'b1;
      tick <= wrap;
    end
  end

  // R1: no tick while held in reset
  assert_no_tick_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick);

  // R3: ticks are single-cycle when the prescaler divides
  assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psc != '0) |=> !tick);

endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  output logic             scl,
  output logic             rise,
  output logic             fall
);
  import sclgen_pkg::*;

  localparam int LW = CNT_W + 1;

  logic [LW-1:0] ccnt;
  logic [LW-1:0] len_low, len_high, len_cur;
  logic [LW-1:0] extra;
  logic          last;

  assign extra    = LW'(extra_ticks(32'(psc)));
  assign len_low  = {1'b0, low_cnt} + extra;
  assign len_high = {1'b0, high_cnt} + extra;
  assign len_cur  = scl ? len_high : len_low;
  assign last     = (ccnt == len_cur - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccnt <= '0;
      scl  <= 1'b1;
      rise <= 1'b0;
      fall <= 1'b0;
    end else if (!en) begin
      ccnt <= '0;
      scl  <= 1'b1;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
      if (tick) begin
        if (last) begin
          ccnt <= '0;
          scl  <= !scl;
          rise <= !scl;
          fall <= scl;
        end else begin
          ccnt <= ccnt + 1'b1;
        end
      end
    end
  end

  // R1: line parked high and strobes quiet while disabled
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl && !rise && !fall));

  // R7: strobes are exclusive and match real edges
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));
  assert_rise_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (scl && !$past(scl)));
  assert_fall_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> (!scl && $past(scl)));

  // R4: while running, SCL only moves after a tick
  assert_move_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && scl != $past(scl)) |-> $past(tick));

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_sel,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic             tick_o,
  output logic             scl_o,
  output logic             scl_rise_o,
  output logic             scl_fall_o
);
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] low_q;
  logic [CNT_W-1:0] high_q;

  sclgen_cfg #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (mod_en),
    .wr     (cfg_wr),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .psc_q  (psc_q),
    .low_q  (low_q),
    .high_q (high_q)
  );

  sclgen_presc #(.PSC_W(PSC_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (mod_en),
    .psc   (psc_q),
    .tick  (tick_o)
  );

  sclgen_phase #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (mod_en),
    .tick     (tick_o),
    .psc      (psc_q),
    .low_cnt  (low_q),
    .high_cnt (high_q),
    .scl      (scl_o),
    .rise     (scl_rise_o),
    .fall     (scl_fall_o)
  );

endmodule

// File: tb/sim_scl_clkgen.sv
`timescale 1ns/1ps
module sim_scl_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        tick_o, scl_o, scl_rise_o, scl_fall_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scl_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .tick_o(tick_o),
    .scl_o(scl_o), .scl_rise_o(scl_rise_o), .scl_fall_o(scl_fall_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int dval(input int p);
    return (p == 0) ? 7 : (p == 1) ? 6 : 5;
  endfunction

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic check_idle(input string req);
    chk(scl_o == 1'b1, req, scl_o, 1);
    chk(!tick_o && !scl_rise_o && !scl_fall_o, req,
        {tick_o, scl_rise_o, scl_fall_o}, 0);
  endtask

  // enable and measure cycles to first low sample; returns via refs
  task automatic first_fall(output int n, output int ftick, output bit fstb);
    n = 0; ftick = 0; fstb = 1'b0;
    @(negedge clk);
    mod_en = 1'b1;
    for (int g = 0; g < 4000; g++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (tick_o && ftick == 0) ftick = n;
      if (!scl_o) begin fstb = scl_fall_o; break; end
    end
  endtask

  // measure how long scl stays at level lv; at entry we sit in first sample of it
  task automatic measure(input bit lv, output int n, output int nt, output bit stb_ok);
    n = 0; nt = 0; stb_ok = 1'b1;
    for (int g = 0; g < 4000; g++) begin
      if (tick_o) nt++;
      @(posedge clk); n++;
      @(negedge clk);
      if (scl_o != lv) begin
        if (lv == 1'b0 && !(scl_rise_o && !scl_fall_o)) stb_ok = 1'b0;
        if (lv == 1'b1 && !(scl_fall_o && !scl_rise_o)) stb_ok = 1'b0;
        break;
      end
      if (scl_rise_o || scl_fall_o) stb_ok = 1'b0;
    end
  endtask

  task automatic run_case(input int p, input int l, input int h);
    int n, ft, nt, d, per;
    bit fs, ok;
    d = dval(p); per = p + 1;
    wr(2'd0, 16'(p));
    wr(2'd1, 16'(l));
    wr(2'd2, 16'(h));
    wr(2'd3, 16'hFFFF);  // R2: select 3 has no effect
    check_idle("R1 idle before enable");
    first_fall(n, ft, fs);
    chk(n == (h + d) * per + 1, "R5 first fall cycle (R2 sel3 ignored)", n, (h + d) * per + 1);
    chk(ft == per, "R3 first tick cycle", ft, per);
    chk(fs, "R7 fall strobe on first low", fs, 1);
    measure(1'b0, n, nt, ok);
    chk(n == (l + d) * per, "R6 low phase cycles", n, (l + d) * per);
    chk(nt == l + d, "R4 low phase ticks", nt, l + d);
    chk(ok, "R7 rise strobe placement", ok, 1);
    measure(1'b1, n, nt, ok);
    chk(n == (h + d) * per, "R6 high phase cycles", n, (h + d) * per);
    chk(nt == h + d, "R4 high phase ticks", nt, h + d);
    chk(ok, "R7 fall strobe placement", ok, 1);
    // mid low phase: drop enable
    @(negedge clk);
    mod_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_idle("R8 disable mid-phase");
    first_fall(n, ft, fs);
    chk(n == (h + d) * per + 1, "R8 restart first fall", n, (h + d) * per + 1);
    @(negedge clk);
    mod_en = 1'b0;
    @(negedge clk);
    check_idle("R1 idle after disable");
  endtask

  initial begin
    int n, ft, nt;
    bit fs, ok;
    repeat (3) @(negedge clk);
    check_idle("R1 reset state");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1 disabled after reset");

    for (int p = 0; p < 4; p++)
      for (int l = 0; l < 3; l++)
        for (int h = 0; h < 3; h++)
          run_case(p, l, h);

    // R2: writes while enabled are ignored
    wr(2'd0, 16'd1);
    wr(2'd1, 16'd1);
    wr(2'd2, 16'd1);
    first_fall(n, ft, fs);
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd9);
    // wait for next low phase start
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (scl_fall_o) break;
    end
    measure(1'b0, n, nt, ok);
    chk(n == 14, "R2 low count unchanged by write while enabled", n, 14);
    measure(1'b1, n, nt, ok);
    chk(n == 14, "R2 high count unchanged by write while enabled", n, 14);
    @(negedge clk);
    mod_en = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule